// File: doc/BRIEF.md
# Programmable Interval Timer with Free-Running Divider

This block is a byte-wide, memory-mapped timer peripheral clocked from a 4.194304 MHz system clock. An internal prescaler turns the clock into a base tick at 262144 Hz. Two counters run from that base tick. The first is a free-running divider byte that advances at 16384 Hz. The second is a programmable up-counter that advances at one of four selectable rates, but only while it is enabled. When the up-counter steps past 0xFF, it reloads from a modulo byte and latches an interrupt request.

Software reaches four byte registers in page 0xFF through a single address, write-enable and data port. Reads are combinational. The core sees the pending interrupt on `irq`. It retires the interrupt by pulsing `irqAck` while it samples that level, so one operation both reports and clears the pending state.

Top module: `ivl_timer`

## Requirements
- R1: A synchronous reset clears the divider, counter, modulo and control bytes, the prescaler, both sub-counters and the interrupt latch. After reset every mapped read returns 0x00 and `irq` is 0.
- R2: Addresses whose upper byte is 0xFF decode their low byte as follows: 0x04 is the divider, 0x05 the counter, 0x06 the modulo byte and 0x07 the control byte. Reads anywhere else return 0x00, and writes anywhere else change no register.
- R3: A base tick occurs on every 16th clock edge counted from reset release. The divider gains one on every 16th base tick (every 256 edges) whatever the enable bit holds, and it wraps from 0xFF to 0x00.
- R4: Any write to the divider address sets the divider to 0x00 whatever the data. The write beats an increment in the same cycle. It does not disturb the prescaler phase.
- R5: Control bits [1:0] pick the counter period in base ticks: code 00 gives 64, 01 gives 1, 10 gives 4 and 11 gives 16.
- R6: Control bit 2 enables the counter. While it is 0, the counter and its rate sub-counter both keep their values, and counting resumes from the held sub-count.
- R7: When the counter steps while at 0xFF, it loads the modulo byte and sets the interrupt latch.
- R8: The interrupt latch holds until `irqAck` is high on a clock edge, which clears it. If an overflow lands on the same edge as the acknowledge, the latch stays set.
- R9: The counter, modulo and control bytes read back exactly the byte last written to them.
- R10: A write to the counter on the same edge as a counter step stores the written byte. That edge produces neither an increment nor an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Register address |
| wrEn | input | 1 | Write strobe for the addressed byte |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Latched overflow interrupt request |
| irqAck | input | 1 | Acknowledge; clears the latch at the edge |

## Verification
The bench builds the block with its default parameters: 16 clocks per base tick, 16 base ticks per divider step, and rate periods of 64, 1, 4 and 16. These values place the divider wrap at edge 65536, which a single run can reach. They also let the bench check all four rate codes with one read each after 3100 edges, where the four results differ. The bench derives every expected value from the edge count since reset release. This allows writes and acknowledges to be placed exactly on step edges, which exercises the priority cases of R4, R8 and R10.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam logic [7:0] PAGE_HI  = 8'hFF;
  localparam logic [5:0] OFF_BLK  = 6'b000001;  // offsets 0x04..0x07
  localparam logic [1:0] IDX_DIV  = 2'd0;
  localparam logic [1:0] IDX_CNT  = 2'd1;
  localparam logic [1:0] IDX_MOD  = 2'd2;
  localparam logic [1:0] IDX_CTL  = 2'd3;
  localparam int         EN_BIT   = 2;

  typedef struct packed {
    logic       wrDiv;
    logic       wrCnt;
    logic       wrMod;
    logic       wrCtl;
    logic       divStep;
    logic       cntStep;
    logic       rdHit;
    logic [1:0] rdIdx;
  } tmr_strobe_t;
endpackage

// File: rtl/ivl_timer_ctrl.sv
module ivl_timer_ctrl
  import ivl_timer_pkg::*;
#(
  parameter int CLK_PER_TICK  = 16,
  parameter int TICKS_PER_DIV = 16,
  parameter int RATE_00       = 64,
  parameter int RATE_01       = 1,
  parameter int RATE_10       = 4,
  parameter int RATE_11       = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] addr,
  input  logic        wrEn,
  input  logic [2:0]  ctlLow,
  output tmr_strobe_t stb
);
  localparam int RATE_MAXA = (RATE_00 > RATE_01) ? RATE_00 : RATE_01;
  localparam int RATE_MAXB = (RATE_10 > RATE_11) ? RATE_10 : RATE_11;
  localparam int RATE_MAX  = (RATE_MAXA > RATE_MAXB) ? RATE_MAXA : RATE_MAXB;
  localparam int RS_W      = (RATE_MAX > 1) ? $clog2(RATE_MAX) : 1;
  localparam int DS_W      = (TICKS_PER_DIV > 1) ? $clog2(TICKS_PER_DIV) : 1;
  localparam int RATE_TBL [4] = '{RATE_00, RATE_01, RATE_10, RATE_11};

  logic            baseTick;
  logic [DS_W-1:0] divSub;
  logic [RS_W-1:0] rateSub;
  logic [RS_W-1:0] rateLast;
  logic            cntOn;
  logic            hit;

  // Prescaler: variant picked by the clocks-per-tick parameter.
  generate
    if (CLK_PER_TICK == 1) begin : g_noPre
      assign baseTick = 1'b1;
    end else begin : g_pre
      localparam int PRE_W = $clog2(CLK_PER_TICK);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (rst || preCnt == PRE_W'(CLK_PER_TICK - 1)) preCnt <= '0;
        else                                           preCnt <= preCnt + 1'b1;
      end
      assign baseTick = (preCnt == PRE_W'(CLK_PER_TICK - 1));
    end
  endgenerate

  // Divider sub-counter runs regardless of the enable bit.
  always_ff @(posedge clk) begin
    if (rst) divSub <= '0;
    else if (baseTick) begin
      if (divSub == DS_W'(TICKS_PER_DIV - 1)) divSub <= '0;
      else                                     divSub <= divSub + 1'b1;
    end
  end

  assign cntOn    = ctlLow[EN_BIT];
  assign rateLast = RS_W'(RATE_TBL[ctlLow[1:0]] - 1);

  // Rate sub-counter: ">=" so a shorter rate picked mid-count fires at once.
  always_ff @(posedge clk) begin
    if (rst) rateSub <= '0;
    else if (baseTick && cntOn) begin
      if (rateSub >= rateLast) rateSub <= '0;
      else                     rateSub <= rateSub + 1'b1;
    end
  end

  assign hit = (addr[15:8] == PAGE_HI) && (addr[7:2] == OFF_BLK);

  always_comb begin
    stb         = '0;
    stb.rdHit   = hit;
    stb.rdIdx   = addr[1:0];
    stb.wrDiv   = wrEn && hit && addr[1:0] == IDX_DIV;
    stb.wrCnt   = wrEn && hit && addr[1:0] == IDX_CNT;
    stb.wrMod   = wrEn && hit && addr[1:0] == IDX_MOD;
    stb.wrCtl   = wrEn && hit && addr[1:0] == IDX_CTL;
    stb.divStep = baseTick && (divSub == DS_W'(TICKS_PER_DIV - 1));
    stb.cntStep = baseTick && cntOn && (rateSub >= rateLast);
  end

  AST_HOLD_SUB: assert property (@(posedge clk) disable iff (rst)
    !cntOn |=> $stable(rateSub)); // R6
  AST_NO_STEP_OFF: assert property (@(posedge clk) disable iff (rst)
    !cntOn |-> !stb.cntStep); // R6
  AST_FAST_RATE: assert property (@(posedge clk) disable iff (rst)
    (cntOn && ctlLow[1:0] == 2'b01 && baseTick) |-> stb.cntStep); // R5
endmodule

// File: rtl/ivl_timer_dp.sv
module ivl_timer_dp
  import ivl_timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tmr_strobe_t       stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqAck,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        ctlLow,
  output logic              irq
);
  logic [DATA_W-1:0] divReg, cntReg, modReg, ctlReg;
  logic              irqLat;
  logic              ovf;

  assign ovf = stb.cntStep && !stb.wrCnt && (cntReg == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      divReg <= '0;
      cntReg <= '0;
      modReg <= '0;
      ctlReg <= '0;
      irqLat <= 1'b0;
    end else begin
      if (stb.wrDiv)        divReg <= '0;
      else if (stb.divStep) divReg <= divReg + 1'b1;

      if (stb.wrCnt)        cntReg <= wrData;
      else if (ovf)         cntReg <= modReg;
      else if (stb.cntStep) cntReg <= cntReg + 1'b1;

      if (stb.wrMod) modReg <= wrData;
      if (stb.wrCtl) ctlReg <= wrData;

      if (ovf)         irqLat <= 1'b1;
      else if (irqAck) irqLat <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdHit) begin
      case (stb.rdIdx)
        IDX_DIV: rdData = divReg;
        IDX_CNT: rdData = cntReg;
        IDX_MOD: rdData = modReg;
        default: rdData = ctlReg;
      endcase
    end
  end

  assign ctlLow = ctlReg[2:0];
  assign irq    = irqLat;

  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (rst)
    stb.wrDiv |=> divReg == '0); // R4
  AST_DIV_STEP: assert property (@(posedge clk) disable iff (rst)
    (stb.divStep && !stb.wrDiv) |=> divReg == $past(divReg) + 1'b1); // R3
  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (stb.cntStep && !stb.wrCnt && cntReg == '1) |=> (cntReg == $past(modReg) && irq)); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !irqAck) |=> irq); // R8
  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (rst)
    stb.wrCnt |=> cntReg == $past(wrData)); // R10
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int CLK_PER_TICK  = 16,
  parameter int TICKS_PER_DIV = 16,
  parameter int RATE_00       = 64,
  parameter int RATE_01       = 1,
  parameter int RATE_10       = 4,
  parameter int RATE_11       = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] addr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        irq,
  input  logic        irqAck
);
  tmr_strobe_t stb;
  logic [2:0]  ctlLow;

  ivl_timer_ctrl #(
    .CLK_PER_TICK (CLK_PER_TICK),
    .TICKS_PER_DIV(TICKS_PER_DIV),
    .RATE_00      (RATE_00),
    .RATE_01      (RATE_01),
    .RATE_10      (RATE_10),
    .RATE_11      (RATE_11)
  ) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr),
    .wrEn  (wrEn),
    .ctlLow(ctlLow),
    .stb   (stb)
  );

  ivl_timer_dp #(.DATA_W(8)) dp_i (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .wrData(wrData),
    .irqAck(irqAck),
    .rdData(rdData),
    .ctlLow(ctlLow),
    .irq   (irq)
  );
endmodule

// File: tb/ivl_timer_tb_top.sv
module ivl_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 16;
  localparam int DIVP       = 256;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        irq;
  logic        irqAck = 1'b0;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] exp;
    bit         isIrq;
    string      tag;
  } item_t;
  item_t sbq[$];
  event chkEv;

  ivl_timer dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irq(irq), .irqAck(irqAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(chkEv);
      #1;
      begin
        item_t it;
        logic [7:0] act;
        it  = sbq.pop_front();
        act = it.isIrq ? {7'b0, irq} : rdData;
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s at edge %0d: actual %02h expected %02h", it.tag, cyc, act, it.exp);
        end
      end
    end
  end

  function automatic logic [7:0] expDiv(int n, int w);
    return 8'(((n / DIVP) - (w / DIVP)) % 256);
  endfunction

  function automatic logic [7:0] expCnt(int n, int c, int r);
    return 8'(((n / TICK) - (c / TICK)) / r);
  endfunction

  task automatic do_reset();
    rst = 1'b1; wrEn = 1'b0; irqAck = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_at(int e, logic [15:0] a, logic [7:0] d);
    while (cyc < e - 1) @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ack_at(int e);
    while (cyc < e - 1) @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic rd_at(int n, logic [15:0] a, logic [7:0] e, string tag);
    item_t it;
    while (cyc < n) @(negedge clk);
    addr = a;
    it.exp = e; it.isIrq = 1'b0; it.tag = tag;
    sbq.push_back(it);
    ->chkEv;
    #2;
  endtask

  task automatic irq_at(int n, logic e, string tag);
    item_t it;
    while (cyc < n) @(negedge clk);
    it.exp = {7'b0, e}; it.isIrq = 1'b1; it.tag = tag;
    sbq.push_back(it);
    ->chkEv;
    #2;
  endtask

  initial begin
    int rates [4];
    rates = '{64, 1, 4, 16};

    // Reset state
    do_reset();
    rd_at(1, 16'hFF04, 8'h00, "R1 div after reset");
    rd_at(2, 16'hFF05, 8'h00, "R1 cnt after reset");
    rd_at(3, 16'hFF06, 8'h00, "R1 mod after reset");
    rd_at(4, 16'hFF07, 8'h00, "R1 ctl after reset");
    irq_at(5, 1'b0, "R1 irq after reset");

    // Map, ignored writes, divider behaviour
    wr_at(10, 16'hFE06, 8'h77);
    wr_at(11, 16'hFF03, 8'h77);
    wr_at(12, 16'hFE04, 8'h00);
    wr_at(13, 16'hFF05, 8'h5A);
    rd_at(20, 16'hFF06, 8'h00, "R2 off-page write ignored");
    rd_at(21, 16'hFE05, 8'h00, "R2 off-page read zero");
    rd_at(22, 16'hFF08, 8'h00, "R2 unmapped read zero");
    rd_at(23, 16'hFF05, 8'h5A, "R9 cnt readback");
    rd_at(600, 16'hFF04, expDiv(600, 0), "R3 div rate, off-page write no clear");
    rd_at(601, 16'hFF05, 8'h5A, "R6 cnt held while disabled");
    wr_at(768, 16'hFF04, 8'hA5);
    rd_at(770, 16'hFF04, 8'h00, "R4 div cleared on step edge");
    rd_at(1030, 16'hFF04, expDiv(1030, 768), "R4 prescaler phase kept");

    // Divider wrap
    do_reset();
    rd_at(65530, 16'hFF04, 8'hFF, "R3 div before wrap");
    rd_at(65540, 16'hFF04, 8'h00, "R3 div wraps");

    // Rate codes
    for (int k = 0; k < 4; k++) begin
      do_reset();
      wr_at(5, 16'hFF07, 8'(4 + k));
      rd_at(3100, 16'hFF05, expCnt(3100, 5, rates[k]), $sformatf("R5 rate code %0d", k));
      rd_at(3101, 16'hFF07, 8'(4 + k), "R9 ctl readback");
    end

    // Enable hold keeps the sub-count
    do_reset();
    wr_at(5, 16'hFF07, 8'h06);
    wr_at(100, 16'hFF07, 8'h02);
    rd_at(250, 16'hFF05, 8'h01, "R6 cnt held after disable");
    wr_at(300, 16'hFF07, 8'h06);
    rd_at(340, 16'hFF05, 8'h02, "R6 sub-count resumes");

    // Overflow, reload, latch, acknowledge, write priority
    do_reset();
    wr_at(3, 16'hFF06, 8'hF0);
    wr_at(4, 16'hFF05, 8'hFE);
    wr_at(5, 16'hFF07, 8'h05);
    rd_at(20, 16'hFF05, 8'hFF, "R7 cnt before overflow");
    irq_at(21, 1'b0, "R7 no irq before overflow");
    rd_at(40, 16'hFF05, 8'hF0, "R7 reload from modulo");
    irq_at(41, 1'b1, "R7 irq on overflow");
    rd_at(50, 16'hFF05, 8'hF1, "R7 count after reload");
    irq_at(100, 1'b1, "R8 irq latched");
    rd_at(101, 16'hFF06, 8'hF0, "R9 mod readback");
    ack_at(150);
    irq_at(160, 1'b0, "R8 ack clears");
    ack_at(288);
    irq_at(295, 1'b1, "R8 overflow beats ack");
    rd_at(296, 16'hFF05, 8'hF0, "R7 second reload");
    wr_at(304, 16'hFF05, 8'h33);
    rd_at(310, 16'hFF05, 8'h33, "R10 write beats step");
    rd_at(330, 16'hFF05, 8'h34, "R10 counting resumes");

    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired at edge %0d: actual running expected done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule